// File: doc/BRIEF.md
# Planar Frame Buffer CPU Write Unit

This block is the processor-facing data path of a frame buffer that stores 16-colour pixels across four byte-wide bit planes. Every byte address holds eight pixels. Bit k of the byte in plane n is bit n of pixel k's colour. A small control file sits behind a two-port access scheme. The host first writes an index to the index port and then reads or writes the selected control word through the data port. The control file sets the write mode, the rotate count, the per-plane fill colour and its per-plane enables, the plane returned on reads, and a per-pixel write mask.

A CPU read takes one clock. It loads four read latches with the addressed byte of every plane and returns the byte of the chosen plane. A CPU write also takes one clock. In that clock all four planes are written at the addressed byte with values built from the CPU byte, the fill colour, the latches and the mask, according to the active write mode. Because the latches hold the result of the last read, pixels outside the mask are put back unchanged. The plane memories are plain arrays inside the block.

Top module: `planar_wr_unit`

## Requirements
- R1: After reset the pixel mask reads 0xFF. The index, fill colour, fill enables, rotate count, read plane and write mode all read 0, and `mem_rdata` is 0.
- R2: With `reg_wr`=1, `reg_sel`=0 sets the index and `reg_sel`=1 writes the control word at that index. With `reg_sel`=1, `reg_rdata` shows that word, and with `reg_sel`=0 it shows the index. The implemented indexes are 0 (fill colour, bits 3:0), 1 (fill enables, bits 3:0), 3 (rotate count, bits 2:0), 4 (read plane, bits 1:0), 5 (write mode, bits 1:0) and 8 (pixel mask, bits 7:0). Unused bits read 0.
- R3: Any other index reads as 0, and a data write there leaves every control word unchanged.
- R4: A cycle with `mem_req`=1 and `mem_we`=0 loads all four latches from `mem_addr`. In the next cycle `mem_rdata` holds the byte of the plane named by the read plane field.
- R5: In mode 0 the CPU byte is rotated right by the rotate count. Mask bits of 1 take the rotated bit, and mask bits of 0 keep the latch bit.
- R6: In mode 0, a plane n whose fill enable bit n is 1 takes fill colour bit n copied to all eight bits, still subject to the mask.
- R7: In mode 1 every plane is written with its own latch byte, whatever the CPU byte is.
- R8: In mode 2, CPU bit n is the colour bit for plane n. Mask bits of 1 take that colour bit, and mask bits of 0 keep the latch bit.
- R9: In mode 3 the CPU byte ANDed with the mask selects the bits that take fill colour bit n in plane n. All other bits keep the latch bit.
- R10: A mask of 0x00 makes every write in every mode store the latch bytes unchanged.
- R11: A write with `mem_req`=1 and `mem_we`=1 updates all four planes at its address in the same clock. A read in the next cycle sees the new data, and other addresses stay untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control port write strobe |
| reg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| reg_wdata | input | 8 | Control port write data |
| reg_rdata | output | 8 | Index or selected control word |
| mem_req | input | 1 | Frame buffer access strobe |
| mem_we | input | 1 | 1 for write, 0 for read |
| mem_addr | input | ADDR_W | Byte address |
| mem_wdata | input | 8 | CPU write byte |
| mem_rdata | output | 8 | Byte of the read plane from the last read |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 byte addresses. Each table vector can use its own address, and the first and last addresses are both reachable for the aliasing check. Every plane is preloaded with a different bit pattern, so a plane swap, a wrong mask polarity or a latch taken from the wrong plane shows up as a wrong byte. Rotate counts of 0, 1, 3 and 7 cover the wrap-around ends of the rotator.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int BYTE_W    = 8;
    localparam int NPLANES   = 4;
    localparam int ROT_W     = $clog2(BYTE_W);
    localparam int PSEL_W    = $clog2(NPLANES);
    localparam int IDX_W     = 8;

    localparam logic [IDX_W-1:0] IX_FILL   = 8'd0;
    localparam logic [IDX_W-1:0] IX_FILLEN = 8'd1;
    localparam logic [IDX_W-1:0] IX_ROT    = 8'd3;
    localparam logic [IDX_W-1:0] IX_RDSEL  = 8'd4;
    localparam logic [IDX_W-1:0] IX_MODE   = 8'd5;
    localparam logic [IDX_W-1:0] IX_MASK   = 8'd8;

    typedef enum logic [1:0] {
        WM_ROTATE = 2'd0,
        WM_LATCH  = 2'd1,
        WM_COLOR  = 2'd2,
        WM_PAINT  = 2'd3
    } wmode_e;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NPLANES-1:0][BYTE_W-1:0] quad_t;

    typedef struct packed {
        logic [NPLANES-1:0] fill;
        logic [NPLANES-1:0] fill_en;
        logic [ROT_W-1:0]   rot;
        logic [PSEL_W-1:0]  rdsel;
        wmode_e             mode;
        byte_t              mask;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        fill:    '0,
        fill_en: '0,
        rot:     '0,
        rdsel:   '0,
        mode:    WM_ROTATE,
        mask:    '1
    };

    function automatic byte_t rotr(input byte_t d, input logic [ROT_W-1:0] n);
        logic [2*BYTE_W-1:0] t;
        t = {d, d} >> n;
        return t[BYTE_W-1:0];
    endfunction

    function automatic byte_t merge(input byte_t src, input byte_t keep, input byte_t sel);
        return (src & sel) | (keep & ~sel);
    endfunction

endpackage

// File: rtl/pfb_regfile.sv
module pfb_regfile
    import pfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  byte_t            reg_wdata,
    output byte_t            reg_rdata,
    output logic [IDX_W-1:0] idx,
    output ctl_t             ctl
);

    logic [IDX_W-1:0] idx_q;
    ctl_t             ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ctl_q <= CTL_RESET;
        end else if (reg_wr) begin
            if (!reg_sel) begin
                idx_q <= reg_wdata;
            end else begin
                case (idx_q)
                    IX_FILL:   ctl_q.fill    <= reg_wdata[NPLANES-1:0];
                    IX_FILLEN: ctl_q.fill_en <= reg_wdata[NPLANES-1:0];
                    IX_ROT:    ctl_q.rot     <= reg_wdata[ROT_W-1:0];
                    IX_RDSEL:  ctl_q.rdsel   <= reg_wdata[PSEL_W-1:0];
                    IX_MODE:   ctl_q.mode    <= wmode_e'(reg_wdata[1:0]);
                    IX_MASK:   ctl_q.mask    <= reg_wdata;
                    default:   ctl_q         <= ctl_q;
                endcase
            end
        end
    end

    byte_t word_rd;

    always_comb begin
        word_rd = '0;
        case (idx_q)
            IX_FILL:   word_rd[NPLANES-1:0] = ctl_q.fill;
            IX_FILLEN: word_rd[NPLANES-1:0] = ctl_q.fill_en;
            IX_ROT:    word_rd[ROT_W-1:0]   = ctl_q.rot;
            IX_RDSEL:  word_rd[PSEL_W-1:0]  = ctl_q.rdsel;
            IX_MODE:   word_rd[1:0]         = ctl_q.mode;
            IX_MASK:   word_rd              = ctl_q.mask;
            default:   word_rd              = '0;
        endcase
    end

    assign reg_rdata = reg_sel ? word_rd : idx_q;
    assign idx       = idx_q;
    assign ctl       = ctl_q;

endmodule

// File: rtl/pfb_combine.sv
module pfb_combine
    import pfb_pkg::*;
(
    input  ctl_t  ctl,
    input  byte_t cpu,
    input  quad_t latch,
    output quad_t wbytes
);

    byte_t rotated;
    assign rotated = rotr(cpu, ctl.rot);

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        byte_t src;
        byte_t sel;

        always_comb begin
            case (ctl.mode)
                WM_ROTATE: begin
                    src = ctl.fill_en[p] ? {BYTE_W{ctl.fill[p]}} : rotated;
                    sel = ctl.mask;
                end
                WM_LATCH: begin
                    src = latch[p];
                    sel = ctl.mask;
                end
                WM_COLOR: begin
                    src = {BYTE_W{cpu[p]}};
                    sel = ctl.mask;
                end
                default: begin
                    src = {BYTE_W{ctl.fill[p]}};
                    sel = cpu & ctl.mask;
                end
            endcase
        end

        assign wbytes[p] = merge(src, latch[p], sel);
    end

endmodule

// File: rtl/pfb_planes.sv
module pfb_planes
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  quad_t             wbytes,
    output quad_t             rbytes
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar p = 0; p < NPLANES; p++) begin : g_mem
        byte_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we) begin
                mem[addr] <= wbytes[p];
            end
        end

        assign rbytes[p] = mem[addr];
    end

endmodule

// File: rtl/planar_wr_unit.sv
module planar_wr_unit
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    output logic [7:0]        mem_rdata
);

    ctl_t             ctl;
    logic [IDX_W-1:0] idx;
    quad_t            latch_q;
    quad_t            plane_rd;
    quad_t            plane_wr;
    byte_t            rdata_q;
    logic             do_write;
    logic             do_read;

    assign do_write = mem_req & mem_we;
    assign do_read  = mem_req & ~mem_we;

    pfb_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .idx       (idx),
        .ctl       (ctl)
    );

    pfb_combine u_comb (
        .ctl    (ctl),
        .cpu    (mem_wdata),
        .latch  (latch_q),
        .wbytes (plane_wr)
    );

    pfb_planes #(.ADDR_W(ADDR_W)) u_planes (
        .clk    (clk),
        .we     (do_write),
        .addr   (mem_addr),
        .wbytes (plane_wr),
        .rbytes (plane_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            rdata_q <= '0;
        end else if (do_read) begin
            latch_q <= plane_rd;
            rdata_q <= plane_rd[ctl.rdsel];
        end
    end

    assign mem_rdata = rdata_q;

endmodule

// File: rtl/pfb_chk.sv
module pfb_chk
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [7:0]        reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_rdata,
    input logic [IDX_W-1:0]  idx,
    input ctl_t              ctl,
    input quad_t             latch_q,
    input quad_t             plane_rd,
    input quad_t             plane_wr
);

    logic known_idx;
    assign known_idx = (idx == IX_FILL) || (idx == IX_FILLEN) || (idx == IX_ROT) ||
                       (idx == IX_RDSEL) || (idx == IX_MODE) || (idx == IX_MASK);

    // R1
    reset_mask_chk: assert property (@(posedge clk)
        rst |=> (ctl.mask == 8'hFF && ctl.mode == WM_ROTATE && mem_rdata == 8'h00));

    // R2
    mode_store_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && idx == IX_MODE) |=> (ctl.mode == $past(reg_wdata[1:0])));

    // R3
    unknown_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && !known_idx) |=> $stable(ctl));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (latch_q == $past(plane_rd)));

    // R4
    plane_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_rdata == $past(plane_rd[ctl.rdsel])));

    // R7
    latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && ctl.mode == WM_LATCH) |-> (plane_wr == latch_q));

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && ctl.mask == 8'h00) |-> (plane_wr == latch_q));

    // R11
    write_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=>
            ((mem_addr != $past(mem_addr)) || (plane_rd == $past(plane_wr))));

endmodule

bind planar_wr_unit pfb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .idx       (idx),
    .ctl       (ctl),
    .latch_q   (latch_q),
    .plane_rd  (plane_rd),
    .plane_wr  (plane_wr)
);

// File: tb/sim_planar_wr_unit.sv
module sim_planar_wr_unit;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          mem_req = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    planar_wr_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  rot;
        logic [3:0]  fill;
        logic [3:0]  fill_en;
        logic [7:0]  mask;
        logic [7:0]  cpu;
        logic [31:0] expq;
    } vec_t;

    localparam logic [31:0] PRE = {8'hC3, 8'h55, 8'h33, 8'h0F};
    localparam int NV = 10;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'hA5, 32'hA5A5A5A5},
        '{2'd0, 3'd3, 4'h0, 4'h0, 8'hFF, 8'h81, 32'h30303030},
        '{2'd0, 3'd1, 4'h0, 4'h0, 8'hF0, 8'h0F, {8'h83, 8'h85, 8'h83, 8'h8F}},
        '{2'd0, 3'd0, 4'h4, 4'h5, 8'hFF, 8'h3C, {8'h3C, 8'hFF, 8'h3C, 8'h00}},
        '{2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 8'hFF, PRE},
        '{2'd2, 3'd0, 4'h0, 4'h0, 8'h3C, 8'hF6, {8'hC3, 8'h7D, 8'h3F, 8'h03}},
        '{2'd3, 3'd0, 4'hA, 4'h0, 8'hF0, 8'h3C, {8'hF3, 8'h45, 8'h33, 8'h0F}},
        '{2'd2, 3'd0, 4'h0, 4'h0, 8'h00, 8'hFF, PRE},
        '{2'd3, 3'd0, 4'hF, 4'h0, 8'h00, 8'hFF, PRE},
        '{2'd0, 3'd7, 4'h0, 4'h0, 8'hFF, 8'h01, 32'h02020202}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_put(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] ix, input logic [7:0] d);
        reg_put(1'b0, ix);
        reg_put(1'b1, d);
    endtask

    task automatic get_reg(input logic [7:0] ix, output logic [7:0] d);
        reg_put(1'b0, ix);
        reg_sel = 1'b1;
        #1 d = reg_rdata;
    endtask

    task automatic mem_rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
        @(negedge clk);
        mem_req = 1'b0;
        d = mem_rdata;
    endtask

    task automatic mem_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic plane_rd(input logic [AW-1:0] a, input int p, output logic [7:0] d);
        set_reg(8'd4, 8'(p));
        mem_rd(a, d);
    endtask

    task automatic preload(input logic [AW-1:0] a, input logic [31:0] q);
        logic [7:0] dummy;
        set_reg(8'd5, 8'd2);
        for (int b = 0; b < 8; b++) begin
            set_reg(8'd8, 8'(1 << b));
            mem_rd(a, dummy);
            mem_wr(a, {4'b0, q[24+b], q[16+b], q[8+b], q[b]});
        end
    endtask

    function automatic string vtag(input vec_t v);
        if (v.mask == 8'h00) return "R10";
        case (v.mode)
            2'd0:    return (v.fill_en != 4'h0) ? "R6" : "R5";
            2'd1:    return "R7";
            2'd2:    return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rdata", mem_rdata, 8'h00);
        reg_sel = 1'b0;
        #1 chk("R1 index", reg_rdata, 8'h00);
        get_reg(8'd8, d); chk("R1 mask", d, 8'hFF);
        get_reg(8'd0, d); chk("R1 fill", d, 8'h00);
        get_reg(8'd5, d); chk("R1 mode", d, 8'h00);
        get_reg(8'd3, d); chk("R1 rot", d, 8'h00);

        // R3: unimplemented index
        set_reg(8'd2, 8'hAA);
        get_reg(8'd2, d); chk("R3 idx2", d, 8'h00);
        set_reg(8'h10, 8'h00);
        get_reg(8'h10, d); chk("R3 idx16", d, 8'h00);
        get_reg(8'd8, d); chk("R3 mask kept", d, 8'hFF);
        get_reg(8'd1, d); chk("R3 fill_en kept", d, 8'h00);

        // R2: write all ones, only field bits stick
        set_reg(8'd0, 8'hFF); get_reg(8'd0, d); chk("R2 fill", d, 8'h0F);
        set_reg(8'd1, 8'hFF); get_reg(8'd1, d); chk("R2 fill_en", d, 8'h0F);
        set_reg(8'd3, 8'hFF); get_reg(8'd3, d); chk("R2 rot", d, 8'h07);
        set_reg(8'd4, 8'hFF); get_reg(8'd4, d); chk("R2 rdsel", d, 8'h03);
        set_reg(8'd5, 8'hFE); get_reg(8'd5, d); chk("R2 mode", d, 8'h02);
        set_reg(8'd8, 8'h5A); get_reg(8'd8, d); chk("R2 mask", d, 8'h5A);
        reg_put(1'b0, 8'd3);
        reg_sel = 1'b0;
        #1 chk("R2 index readback", reg_rdata, 8'h03);
        set_reg(8'd0, 8'h00); set_reg(8'd1, 8'h00); set_reg(8'd3, 8'h00);

        // Table walk: R4, R5..R10, R11
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            a = AW'(i);
            preload(a, PRE);
            set_reg(8'd3, {5'b0, VECS[i].rot});
            set_reg(8'd0, {4'b0, VECS[i].fill});
            set_reg(8'd1, {4'b0, VECS[i].fill_en});
            set_reg(8'd8, VECS[i].mask);
            set_reg(8'd5, {6'b0, VECS[i].mode});
            mem_rd(a, d);
            mem_wr(a, VECS[i].cpu);
            for (int p = 0; p < 4; p++) begin
                plane_rd(a, p, d);
                chk(vtag(VECS[i]), d, VECS[i].expq[8*p +: 8]);
            end
        end

        // R4: read plane select picks preloaded plane bytes
        preload(AW'(12), PRE);
        for (int p = 0; p < 4; p++) begin
            plane_rd(AW'(12), p, d);
            chk("R4 plane pick", d, PRE[8*p +: 8]);
        end

        // R11: same-cycle commit, no aliasing between first and last address
        set_reg(8'd5, 8'd0); set_reg(8'd3, 8'd0);
        set_reg(8'd1, 8'd0); set_reg(8'd8, 8'hFF);
        set_reg(8'd4, 8'd2);
        mem_wr(AW'(15), 8'h5A);
        mem_rd(AW'(15), d); chk("R11 last addr", d, 8'h5A);
        mem_wr(AW'(0), 8'hC6);
        mem_rd(AW'(0), d);  chk("R11 first addr", d, 8'hC6);
        mem_rd(AW'(15), d); chk("R11 no alias", d, 8'h5A);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule